// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is a storage register of `WIDTH` bits (eight by default) that can hold its value, shift toward the high bit, shift toward the low bit, or capture a parallel word. Parallel data goes in and out over one shared bus. At the block edge this bus is split into `bus_in`, `bus_out` and a drive-enable `bus_oe`, so that a pad or a bus model can build the three-state line. Picking the parallel-capture mode always releases the bus, which lets an outside source drive the word that gets captured.

Clearing is synchronous and active low. The lowest and highest register bits also leave the block on serial outputs that are never released. They are meant to be wired to the serial inputs of a neighbouring instance, so that instances can be chained into registers of any multiple of the width.

Top module: `ushift_bidir`

## Requirements
- R1: With `fsel` = 2'b00 (`fsel[1]` is the upper select, `fsel[0]` the lower) and `clr_n` high, the register keeps its value across a rising clock edge.
- R2: With `fsel` = 2'b01 and `clr_n` high, each rising edge moves bit i into bit i+1, and bit 0 takes `ser_r_in`.
- R3: With `fsel` = 2'b10 and `clr_n` high, each rising edge moves bit i+1 into bit i, and the top bit takes `ser_l_in`.
- R4: With `fsel` = 2'b11 and `clr_n` high, the rising edge captures `bus_in` into the register.
- R5: When `clr_n` is low at a rising edge, the register becomes all zeros, whatever the value of `fsel`.
- R6: `bus_oe` is high exactly when `oc_a_n` and `oc_b_n` are both low and `fsel` is not 2'b11. It responds in the same cycle, with no register in the path.
- R7: `bus_out` always shows the register contents, in every mode, so the register can be read whenever the drivers are enabled.
- R8: `q_lo` equals register bit 0 and `q_hi` equals the top register bit at all times, whatever `bus_oe` is.
- R9: When two instances are chained (the low instance's `q_hi` goes to the high instance's `ser_r_in`, and the high instance's `q_lo` goes to the low instance's `ser_l_in`), they behave as one register of twice the width in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Synchronous clear, active low |
| fsel | input | 2 | Function select: 00 hold, 01 shift up, 10 shift down, 11 capture |
| oc_a_n | input | 1 | First bus drive control, active low |
| oc_b_n | input | 1 | Second bus drive control, active low |
| ser_r_in | input | 1 | Serial bit entering bit 0 on shift up |
| ser_l_in | input | 1 | Serial bit entering the top bit on shift down |
| bus_in | input | WIDTH | Word sampled from the shared bus |
| bus_out | output | WIDTH | Register contents offered to the shared bus |
| bus_oe | output | 1 | Bus driver enable; low means high impedance |
| q_lo | output | 1 | Register bit 0, always driven |
| q_hi | output | 1 | Top register bit, always driven |

## Verification
The register contents, along with `bus_out`, `q_lo` and `q_hi`, change one rising edge after the controls that select an operation. `bus_oe` is combinational, so it follows its inputs within the same cycle. The bench changes its inputs just after a falling edge and updates its 16-bit reference model at each rising edge. At the next falling edge it compares the registered results against the model, and in that same falling-edge window it compares `bus_oe` against the inputs currently applied. Each comparison is tagged with the mode that was in force at the edge that produced it.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_CAPT = 2'b11
    } mode_t;

endpackage

// File: rtl/ushift_decode.sv
module ushift_decode
    import ushift_pkg::*;
(
    input  logic [1:0] fsel,
    input  logic       oc_a_n,
    input  logic       oc_b_n,
    output mode_t      mode,
    output logic       drive_en
);

    always_comb begin
        mode     = mode_t'(fsel);
        drive_en = !oc_a_n && !oc_b_n && (mode != MODE_CAPT);
    end

endmodule

// File: rtl/ushift_stage.sv
module ushift_stage
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  mode_t            mode,
    input  logic             ser_r_in,
    input  logic             ser_l_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] data
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic             live;
        logic [WIDTH-1:0] word;
    } stage_t;

    stage_t st_d, st_q;
    logic [WIDTH-1:0] next_bit;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_below, from_above;
        if (i == 0) begin : g_lo
            assign from_below = ser_r_in;
        end else begin : g_lo_mid
            assign from_below = st_q.word[i-1];
        end
        if (i == TOP) begin : g_hi
            assign from_above = ser_l_in;
        end else begin : g_hi_mid
            assign from_above = st_q.word[i+1];
        end
        always_comb begin
            unique case (mode)
                MODE_UP:   next_bit[i] = from_below;
                MODE_DOWN: next_bit[i] = from_above;
                MODE_CAPT: next_bit[i] = par_in[i];
                default:   next_bit[i] = st_q.word[i];
            endcase
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.live = st_q.live | !clr_n;
        if (!clr_n) begin
            st_d.word = '0;
        end else begin
            st_d.word = next_bit;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign data = st_q.word;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!st_q.live)
        !clr_n |=> data == '0); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!st_q.live)
        (clr_n && mode == MODE_HOLD) |=> $stable(data)); // R1
    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!st_q.live)
        (clr_n && mode == MODE_UP) |=> data == {$past(data[TOP-1:0]), $past(ser_r_in)}); // R2
    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!st_q.live)
        (clr_n && mode == MODE_DOWN) |=> data == {$past(ser_l_in), $past(data[TOP:1])}); // R3
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!st_q.live)
        (clr_n && mode == MODE_CAPT) |=> data == $past(par_in)); // R4

endmodule

// File: rtl/ushift_bidir.sv
module ushift_bidir
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       fsel,
    input  logic             oc_a_n,
    input  logic             oc_b_n,
    input  logic             ser_r_in,
    input  logic             ser_l_in,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             q_lo,
    output logic             q_hi
);

    localparam int TOP = WIDTH - 1;

    mode_t            mode;
    logic             drive_en;
    logic [WIDTH-1:0] word;

    ushift_decode u_dec (
        .fsel     (fsel),
        .oc_a_n   (oc_a_n),
        .oc_b_n   (oc_b_n),
        .mode     (mode),
        .drive_en (drive_en)
    );

    ushift_stage #(.WIDTH(WIDTH)) u_stage (
        .clk      (clk),
        .clr_n    (clr_n),
        .mode     (mode),
        .ser_r_in (ser_r_in),
        .ser_l_in (ser_l_in),
        .par_in   (bus_in),
        .data     (word)
    );

    assign bus_out = word;
    assign bus_oe  = drive_en;
    assign q_lo    = word[0];
    assign q_hi    = word[TOP];

    always_comb begin
        if (fsel == 2'b11) begin
            AST_CAPT_RELEASES: assert (!bus_oe); // R6
        end
        if (oc_a_n || oc_b_n) begin
            AST_CTRL_RELEASES: assert (!bus_oe); // R6
        end
    end

endmodule

// File: tb/sim_ushift_bidir.sv
module sim_ushift_bidir;

    logic        clk = 1'b0;
    logic        clr_n = 1'b0;
    logic [1:0]  fsel = 2'b00;
    logic        oc_a_n = 1'b1, oc_b_n = 1'b1;
    logic        ser_r = 1'b0, ser_l = 1'b0;
    logic [15:0] bus_in = '0;
    logic [7:0]  out0, out1;
    logic        oe0, oe1, lo0, hi0, lo1, hi1;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    ushift_bidir #(.WIDTH(8)) u0 (
        .clk(clk), .clr_n(clr_n), .fsel(fsel), .oc_a_n(oc_a_n), .oc_b_n(oc_b_n),
        .ser_r_in(ser_r), .ser_l_in(lo1), .bus_in(bus_in[7:0]),
        .bus_out(out0), .bus_oe(oe0), .q_lo(lo0), .q_hi(hi0)
    );

    ushift_bidir #(.WIDTH(8)) u1 (
        .clk(clk), .clr_n(clr_n), .fsel(fsel), .oc_a_n(oc_a_n), .oc_b_n(oc_b_n),
        .ser_r_in(hi0), .ser_l_in(ser_l), .bus_in(bus_in[15:8]),
        .bus_out(out1), .bus_oe(oe1), .q_lo(lo1), .q_hi(hi1)
    );

    // Behavioural reference: one 16-bit value for the chained pair
    logic [15:0] model;
    string       tag = "R5";
    bit          started = 0;

    always @(posedge clk) begin
        started <= 1;
        if (!clr_n) begin
            model = 16'h0000; tag = "R5";
        end else begin
            case (fsel)
                2'b01: begin model = {model[14:0], ser_r}; tag = "R2"; end
                2'b10: begin model = {ser_l, model[15:1]}; tag = "R3"; end
                2'b11: begin model = bus_in;                tag = "R4"; end
                default: tag = "R1";
            endcase
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            logic exp_oe;
            exp_oe = !oc_a_n && !oc_b_n && (fsel != 2'b11);
            chk({tag, "/R7/R9 bus_out"}, {out1, out0}, model);
            chk("R6 bus_oe", {14'h0, oe1, oe0}, {14'h0, exp_oe, exp_oe});
            chk("R8 serial ends", {12'h0, hi1, lo1, hi0, lo0},
                {12'h0, model[15], model[8], model[7], model[0]});
        end
    end

    task automatic step(input logic c, input logic [1:0] f, input logic a, input logic b,
                        input logic sr, input logic sl, input logic [15:0] d);
        @(negedge clk);
        #1;
        clr_n = c; fsel = f; oc_a_n = a; oc_b_n = b; ser_r = sr; ser_l = sl; bus_in = d;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R5: clear from power-up
        step(0, 2'b00, 1, 1, 0, 0, 16'hFFFF);
        step(0, 2'b11, 0, 0, 0, 0, 16'hFFFF);
        // R4 capture, drivers released (R6) even with controls low
        step(1, 2'b11, 0, 0, 0, 0, 16'hA55A);
        // R1 hold with every control combination (R6, R7)
        step(1, 2'b00, 0, 0, 1, 1, 16'h1234);
        step(1, 2'b00, 1, 0, 1, 1, 16'h1234);
        step(1, 2'b00, 0, 1, 0, 1, 16'h1234);
        step(1, 2'b00, 1, 1, 1, 0, 16'h1234);
        // R2 shift up across the chain boundary (R9)
        for (int i = 0; i < 20; i++) step(1, 2'b01, 0, 0, 1'(i % 3 == 0), 0, 16'h0);
        // R3 shift down across the chain boundary (R9)
        for (int i = 0; i < 20; i++) step(1, 2'b10, 0, 0, 0, 1'(i % 2), 16'h0);
        // R5 priority of clear over capture and shift
        step(1, 2'b11, 0, 0, 0, 0, 16'hFFFF);
        step(0, 2'b11, 0, 0, 0, 0, 16'h5A5A);
        step(1, 2'b11, 0, 0, 0, 0, 16'h8001);
        step(0, 2'b01, 0, 0, 1, 1, 16'h0);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1] | r[2], r[4:3], r[5], r[6], r[7], r[8], r[31:16]);
        end
        step(1, 2'b00, 1, 1, 0, 0, 16'h0);
        @(negedge clk);
        #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule